// File: doc/BRIEF.md
# Reset Cause and Software Reset Register

This block holds a single 32-bit word that tells software why the system last came out of reset, and lets software ask for a new reset. The five meaningful bits sit at the top of the word. Three of them are sticky causes that software acknowledges by writing ones: the initial power-up, a power button press and an external-reset button press. The other two are soft-reset trigger bits that take whatever value is written to them.

A write that sets a trigger bit also starts a reset. Shortly afterwards the block raises a one-cycle system reset request, together with a kind flag that says whether a full power-on style reset or a lighter externally-initiated reset is wanted.

The word sits behind a simple synchronous read/write port and answers anywhere in an 8-byte address window. A dedicated power-on input marks the start of life. The first system reset after it loads the power-up cause, and every later system reset leaves the word untouched, so software can read the cause after the reset it asked for.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_i` is high the word is cleared to 0x0000_0000 and the block forgets any earlier system reset; the request output stays low.
- R2: The first cycle of `rst_i` after `por_i` loads the word with only bit 31 set (0x8000_0000).
- R3: Any later `rst_i` leaves the word unchanged.
- R4: Bits 31, 28 and 27 are cleared by a write with a one in that position. A zero written there leaves the bit unchanged.
- R5: Bits 30 (soft power-on trigger) and 29 (soft external-reset trigger) take the written value on every accepted write.
- R6: Bits 26 to 0 always read as zero, whatever is written to them.
- R7: A high cycle on `btn_por_i` sets bit 28, and a high cycle on `btn_xir_i` sets bit 27. When a set and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R8: An accepted write with bit 30 or bit 29 set drives `sys_rst_req_o` high for exactly one cycle, in the cycle after the write's clock edge. A write with neither bit set raises no request.
- R9: With a request, `sys_rst_kind_o` is 1 when bit 30 was written as one (this wins over bit 29) and 0 when only bit 29 was written as one.
- R10: Writes and reads are accepted only when `addr_i[15:3]` equals 0xF020>>3, that is byte offsets 0xF020 to 0xF027. Writes elsewhere are ignored, and reads elsewhere return 0.
- R11: `rd_data_o` is registered. It shows the word one cycle after `rd_en_i` is sampled, and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, synchronous, active high |
| rst_i | input | 1 | System reset, synchronous, active high |
| addr_i | input | 16 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| btn_por_i | input | 1 | Power button event pulse |
| btn_xir_i | input | 1 | External-reset button event pulse |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| sys_rst_kind_o | output | 1 | 1 requests a power-on style reset, 0 an externally-initiated one |

## Verification
The hardest case to reach from the ports is the difference between the first reset and every later one. It only shows up when a `rst_i` arrives while the word already holds a value that the first-reset load would overwrite. The bench first fills the word with trigger and button bits, then pulses `rst_i` and reads back the unchanged value. It then raises `por_i` and pulses `rst_i` again to see the power-up value come back. The same-cycle clash between a button event and a write-one-to-clear is hit by driving the button and the write on the same clock edge.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned BIT_POR      = 31;
  localparam int unsigned BIT_SOFT_POR = 30;
  localparam int unsigned BIT_SOFT_XIR = 29;
  localparam int unsigned BIT_BTN_POR  = 28;
  localparam int unsigned BIT_BTN_XIR  = 27;

  localparam logic [WORD_W-1:0] CLR1_MASK = (WORD_W'(1) << BIT_POR)
                                          | (WORD_W'(1) << BIT_BTN_POR)
                                          | (WORD_W'(1) << BIT_BTN_XIR);
  localparam logic [WORD_W-1:0] LOAD_MASK = (WORD_W'(1) << BIT_SOFT_POR)
                                          | (WORD_W'(1) << BIT_SOFT_XIR);
  localparam logic [WORD_W-1:0] FIRST_VAL = (WORD_W'(1) << BIT_POR);

  typedef enum logic {
    KIND_XIR = 1'b0,
    KIND_POR = 1'b1
  } req_kind_e;
endpackage

// File: rtl/rcsr_addr_dec.sv
module rcsr_addr_dec #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LG2 = 3,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [WIN_LG2-1:0] unused_low;
  assign unused_low = addr_i[WIN_LG2-1:0];
  assign hit_o = (addr_i[ADDR_W-1:WIN_LG2] == BASE[ADDR_W-1:WIN_LG2]);
endmodule

// File: rtl/rcsr_first_trk.sv
module rcsr_first_trk (
  input  logic clk,
  input  logic por_i,
  input  logic rst_i,
  output logic first_o
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (por_i)      seen_q <= 1'b0;
    else if (rst_i) seen_q <= 1'b1;
  end

  assign first_o = rst_i & ~seen_q;

  // R3: once a reset has been taken, only power-on forgets it
  a_r3_seen_sticky: assert property (@(posedge clk) disable iff (por_i)
    seen_q |=> seen_q);
endmodule

// File: rtl/rcsr_status.sv
module rcsr_status
  import rcsr_pkg::*;
(
  input  logic              clk,
  input  logic              por_i,
  input  logic              rst_i,
  input  logic              first_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wd_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[BIT_BTN_POR] = btn_por_i;
    set_vec[BIT_BTN_XIR] = btn_xir_i;
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (CLR1_MASK[i]) begin : g_clr1
      logic b_q;
      always_ff @(posedge clk) begin
        if (por_i)      b_q <= 1'b0;
        else if (rst_i) b_q <= first_i ? FIRST_VAL[i] : b_q;
        else            b_q <= (b_q & ~(wr_i & wd_i[i])) | set_vec[i];
      end
      assign q_o[i] = b_q;
    end else if (LOAD_MASK[i]) begin : g_load
      logic b_q;
      logic unused_set;
      assign unused_set = set_vec[i];
      always_ff @(posedge clk) begin
        if (por_i)      b_q <= 1'b0;
        else if (rst_i) b_q <= first_i ? FIRST_VAL[i] : b_q;
        else if (wr_i)  b_q <= wd_i[i];
      end
      assign q_o[i] = b_q;
    end else begin : g_none
      logic unused_wd;
      assign unused_wd = wd_i[i] ^ set_vec[i];
      assign q_o[i] = 1'b0;
    end
  end

  // R4: a one written to the power-on cause clears it
  a_r4_clear_por: assert property (@(posedge clk) disable iff (rst_i || por_i)
    (wr_i && wd_i[BIT_POR]) |=> !q_o[BIT_POR]);
  // R7: a button event wins over a same-cycle clear
  a_r7_btn_por_wins: assert property (@(posedge clk) disable iff (rst_i || por_i)
    btn_por_i |=> q_o[BIT_BTN_POR]);
  a_r7_btn_xir_wins: assert property (@(posedge clk) disable iff (rst_i || por_i)
    btn_xir_i |=> q_o[BIT_BTN_XIR]);
  // R5: trigger bits follow the written value
  a_r5_soft_por_loaded: assert property (@(posedge clk) disable iff (rst_i || por_i)
    wr_i |=> (q_o[BIT_SOFT_POR] == $past(wd_i[BIT_SOFT_POR])));
endmodule

// File: rtl/rcsr_req_gen.sv
module rcsr_req_gen
  import rcsr_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic rst_i,
  input  logic wr_i,
  input  logic soft_por_i,
  input  logic soft_xir_i,
  output logic req_o,
  output logic kind_o
);
  logic      req_q;
  req_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (por_i || rst_i) begin
      req_q  <= 1'b0;
      kind_q <= KIND_XIR;
    end else begin
      req_q <= wr_i & (soft_por_i | soft_xir_i);
      if (wr_i && soft_por_i)      kind_q <= KIND_POR;
      else if (wr_i && soft_xir_i) kind_q <= KIND_XIR;
    end
  end

  assign req_o  = req_q;
  assign kind_o = (kind_q == KIND_POR);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcsr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LG2 = 3,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic              sys_rst_req_o,
  output logic              sys_rst_kind_o
);
  logic              hit;
  logic              wr_ok;
  logic              first;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rd_q;

  rcsr_addr_dec #(.ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .BASE(BASE)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign wr_ok = wr_en_i & hit;

  rcsr_first_trk u_first (
    .clk     (clk),
    .por_i   (por_i),
    .rst_i   (rst_i),
    .first_o (first)
  );

  rcsr_status u_stat (
    .clk       (clk),
    .por_i     (por_i),
    .rst_i     (rst_i),
    .first_i   (first),
    .wr_i      (wr_ok),
    .wd_i      (wr_data_i),
    .btn_por_i (btn_por_i),
    .btn_xir_i (btn_xir_i),
    .q_o       (word)
  );

  rcsr_req_gen u_req (
    .clk        (clk),
    .por_i      (por_i),
    .rst_i      (rst_i),
    .wr_i       (wr_ok),
    .soft_por_i (wr_data_i[BIT_SOFT_POR]),
    .soft_xir_i (wr_data_i[BIT_SOFT_XIR]),
    .req_o      (sys_rst_req_o),
    .kind_o     (sys_rst_kind_o)
  );

  always_ff @(posedge clk) begin
    if (por_i || rst_i) rd_q <= '0;
    else if (rd_en_i)   rd_q <= hit ? word : '0;
  end

  assign rd_data_o = rd_q;

  // R8: a trigger write is followed by a request
  a_r8_req_follows: assert property (@(posedge clk) disable iff (rst_i || por_i)
    (wr_en_i && hit && (wr_data_i[BIT_SOFT_POR] || wr_data_i[BIT_SOFT_XIR]))
    |=> sys_rst_req_o);
  // R9: power-on kind only when bit 30 was written
  a_r9_kind_por: assert property (@(posedge clk) disable iff (rst_i || por_i)
    (wr_en_i && hit && wr_data_i[BIT_SOFT_POR]) |=> sys_rst_kind_o);
  // R10: a write outside the window leaves the word alone
  a_r10_miss_stable: assert property (@(posedge clk) disable iff (rst_i || por_i)
    (wr_en_i && !hit && !btn_por_i && !btn_xir_i) |=> $stable(word));
  // R1: no request while power-on is held
  a_r1_no_req_por: assert property (@(posedge clk)
    por_i |=> !sys_rst_req_o);
endmodule

// File: tb/rst_cause_reg_tb_top.sv
`timescale 1ns/1ps
module rst_cause_reg_tb_top;
  logic        clk = 1'b0;
  logic        por_i = 1'b0, rst_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        btn_por_i = 1'b0, btn_xir_i = 1'b0;
  logic        sys_rst_req_o, sys_rst_kind_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [15:0] A_REG = 16'hF020;

  always #4 clk = ~clk;

  rst_cause_reg dut_i (
    .clk(clk), .por_i(por_i), .rst_i(rst_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .btn_por_i(btn_por_i), .btn_xir_i(btn_xir_i),
    .sys_rst_req_o(sys_rst_req_o), .sys_rst_kind_o(sys_rst_kind_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // returns at the negedge after the write edge
  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic pulse_rst(input bit with_por);
    @(negedge clk);
    por_i = with_por; rst_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    @(negedge clk);
    rst_i = 1'b0;
  endtask

  task automatic t_power_on();
    logic [31:0] v;
    @(negedge clk); por_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 req low in por", {31'd0, sys_rst_req_o}, 32'd0);
    por_i = 1'b0;
    do_read(A_REG, v);
    check("R1 word cleared", v, 32'h0);
  endtask

  task automatic t_first_reset();
    logic [31:0] v;
    pulse_rst(1'b0);
    do_read(A_REG, v);
    check("R2 first reset load", v, 32'h8000_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    do_write(A_REG, 32'h0);
    do_read(A_REG, v);
    check("R4 zero keeps bit31", v, 32'h8000_0000);
    do_write(A_REG, 32'h8000_0000);
    check("R8 no req without trigger", {31'd0, sys_rst_req_o}, 32'd0);
    do_read(A_REG, v);
    check("R4 one clears bit31", v, 32'h0);
  endtask

  task automatic t_buttons();
    logic [31:0] v;
    @(negedge clk); btn_por_i = 1'b1;
    @(negedge clk); btn_por_i = 1'b0;
    do_read(A_REG, v);
    check("R7 btn power sets 28", v, 32'h1000_0000);
    @(negedge clk); btn_xir_i = 1'b1;
    @(negedge clk); btn_xir_i = 1'b0;
    do_read(A_REG, v);
    check("R7 btn ext sets 27", v, 32'h1800_0000);
    do_write(A_REG, 32'h0800_0000);
    do_read(A_REG, v);
    check("R4 clear bit27 only", v, 32'h1000_0000);
    // clash: set and clear of bit 27 on one edge
    @(negedge clk);
    addr_i = A_REG; wr_data_i = 32'h0800_0000; wr_en_i = 1'b1; btn_xir_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; btn_xir_i = 1'b0; wr_data_i = '0;
    do_read(A_REG, v);
    check("R7 set wins clash", v, 32'h1800_0000);
    do_write(A_REG, 32'h1800_0000);
    do_read(A_REG, v);
    check("R4 clear both buttons", v, 32'h0);
  endtask

  task automatic t_triggers();
    logic [31:0] v;
    do_write(A_REG, 32'h4000_0000);
    check("R8 req after soft por", {31'd0, sys_rst_req_o}, 32'd1);
    check("R9 kind por", {31'd0, sys_rst_kind_o}, 32'd1);
    @(negedge clk);
    check("R8 req single cycle", {31'd0, sys_rst_req_o}, 32'd0);
    do_read(A_REG, v);
    check("R5 bit30 stored", v, 32'h4000_0000);
    do_write(A_REG, 32'h2000_0000);
    check("R8 req after soft xir", {31'd0, sys_rst_req_o}, 32'd1);
    check("R9 kind xir", {31'd0, sys_rst_kind_o}, 32'd0);
    do_read(A_REG, v);
    check("R5 bit30 cleared bit29 set", v, 32'h2000_0000);
    do_write(A_REG, 32'h6000_0000);
    check("R9 bit30 wins", {31'd0, sys_rst_kind_o}, 32'd1);
    do_write(A_REG, 32'h0);
    check("R8 no req on zero write", {31'd0, sys_rst_req_o}, 32'd0);
    do_read(A_REG, v);
    check("R5 both triggers cleared", v, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    do_write(A_REG, 32'h07FF_FFFF);
    do_read(A_REG, v);
    check("R6 low bits read zero", v, 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    do_write(16'hF027, 32'h2000_0000);
    check("R10 top of window accepted", {31'd0, sys_rst_req_o}, 32'd1);
    do_write(16'hF018, 32'h4000_0000);
    check("R10 below window no req", {31'd0, sys_rst_req_o}, 32'd0);
    do_write(16'hF028, 32'h4000_0000);
    do_read(A_REG, v);
    check("R10 misses ignored", v, 32'h2000_0000);
    do_read(16'hF028, v);
    check("R10 miss reads zero", v, 32'h0);
    do_read(16'hF024, v);
    check("R11 read data after one cycle", v, 32'h2000_0000);
    @(negedge clk);
    check("R11 read data held", rd_data_o, 32'h2000_0000);
  endtask

  task automatic t_later_reset();
    logic [31:0] v;
    @(negedge clk); btn_por_i = 1'b1;
    @(negedge clk); btn_por_i = 1'b0;
    pulse_rst(1'b0);
    do_read(A_REG, v);
    check("R3 later reset keeps word", v, 32'h3000_0000);
    pulse_rst(1'b1);
    pulse_rst(1'b0);
    do_read(A_REG, v);
    check("R2 first reset after por", v, 32'h8000_0000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_power_on();
    t_first_reset();
    t_w1c();
    t_buttons();
    t_triggers();
    t_unused();
    t_decode();
    t_later_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule